// File: doc/BRIEF.md
# PWM Ramp Instruction Sequencer

This block drives one pulse-width output from a small stored program rather than from a static compare value. An 8-bit duty level is compared against a free-running 8-bit counter, and the counter advances once per timebase tick. The level is changed by instructions that the channel fetches and executes in a loop. The instructions can force the output fully off or fully on. They can also move the level up or down by one at a programmed step period, and they can send execution back to the first word.

The host loads a program of up to 64 sixteen-bit words through a byte-wide write port, while the channel's run bit is low. Each word takes two byte writes, high byte first. Raising the run bit starts the program at word 0 with the level at zero. Lowering the run bit stops the channel and drives the output low.

Top module: `pwm_ramp_seq`

## Requirements
- R1: The duty counter is 8 bits wide. It advances by one on every cycle with `tick` high and wraps from 0xFF to 0x00. It holds on cycles without `tick`.
- R2: `pwm_out` is high only in a cycle whose previous cycle had `run_en` high, and then only when force-on is active, or when force-off is inactive and the level is strictly greater than the counter. It is low in every cycle that follows a cycle with `run_en` low.
- R3: While `run_en` is low, each `wr_valid` byte is taken at a byte pointer that then advances. An even byte becomes the high half of word pointer/2. The following odd byte completes that word. While `run_en` is high, writes are ignored and the pointer is returned to word 0.
- R4: Word 0x0000 jumps to word 0. Any word with bit 15 and bit 13 both set also jumps to word 0.
- R5: Word 0x007F sets force-off. Word 0x00FF sets force-on. Each clears the other force and advances to the next word. A ramp start clears both forces.
- R6: Any other word with bit 15 clear, a non-zero field in bits 13:8 and a non-zero field in bits 6:0 is a ramp. Bits 6:0 give the number of steps. Bit 7 gives the direction (0 up, 1 down). Bits 13:8 give the step time in ticks, and bit 14 multiplies the step time by 512. The level moves by one at the end of each step period.
- R7: The ramp level saturates at 0x00 going down and at 0xFF going up, while steps keep being counted. After its last step, the ramp advances to the next word.
- R8: While `run_en` is low, the program counter and the level are held at zero, so each 0-to-1 transition of `run_en` restarts from word 0 at level 0.
- R9: Every other word executes as a no-op that advances to the next word in one cycle. This includes bit 15 set with bit 13 clear, a zero step time, and a zero step count. The program counter wraps after word 63.
- R10: While `run_en` is high, the level changes only in cycles with `tick` high, and never by more than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| tick | input | 1 | Timebase tick, one cycle wide |
| run_en | input | 1 | Channel run bit; low allows program loading |
| wr_valid | input | 1 | Program byte write strobe |
| wr_byte | input | 8 | Program byte, high byte of a word first |
| pwm_out | output | 1 | Pulse-width output |

## Verification
The assertions assume that `tick` is a single-cycle strobe in the clock domain. They also assume that every word the channel will reach has been written before `run_en` rises. Unwritten words hold unknown content, and a program that reaches one leaves the behaviour unspecified. The stimulus loads each program completely, including a closing jump or branch. All changes to `run_en` and writes are driven away from the clock edge. Writes made while the channel runs are chosen so that, if accepted, they would visibly change the output.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

  localparam int BYTE_W   = 8;
  localparam int WORD_W   = 2 * BYTE_W;
  localparam int STEPS_W  = 7;
  localparam int STIME_W  = 6;
  localparam int PSC_SH   = 9;
  localparam int PER_W    = STIME_W + PSC_SH;

  localparam logic [WORD_W-1:0] W_HOME = 16'h0000;
  localparam logic [WORD_W-1:0] W_OFF  = 16'h007F;
  localparam logic [WORD_W-1:0] W_ON   = 16'h00FF;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_HOME,
    OP_OFF,
    OP_ON,
    OP_RAMP
  } op_e;

  typedef struct packed {
    op_e                  op;
    logic                 down;
    logic [STEPS_W-1:0]   steps;
    logic [STIME_W-1:0]   stime;
    logic                 slow;
  } instr_t;

endpackage

// File: rtl/pwm_prog_store.sv
module pwm_prog_store
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_ni,
  input  logic                     load_ok,
  input  logic                     wr_valid,
  input  logic [BYTE_W-1:0]        wr_byte,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [WORD_W-1:0]        rd_word
);

  localparam int AW = $clog2(DEPTH);

  logic [AW:0]         ptr_q, ptr_d;
  logic [BYTE_W-1:0]   hi_q, hi_d;
  logic                we;
  logic [WORD_W-1:0]   mem [DEPTH];

  always_comb begin
    ptr_d = ptr_q;
    hi_d  = hi_q;
    we    = 1'b0;
    if (!load_ok) begin
      ptr_d = '0;
    end else if (wr_valid) begin
      ptr_d = ptr_q + 1'b1;
      if (!ptr_q[0]) hi_d = wr_byte;
      else           we   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      hi_q  <= '0;
    end else begin
      ptr_q <= ptr_d;
      hi_q  <= hi_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[ptr_q[AW:1]] <= {hi_q, wr_byte};
  end

  assign rd_word = mem[rd_addr];

endmodule

// File: rtl/pwm_instr_decode.sv
module pwm_instr_decode
  import pwm_seq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output instr_t            ins
);

  always_comb begin
    ins.op    = OP_NOP;
    ins.down  = word[7];
    ins.steps = word[STEPS_W-1:0];
    ins.stime = word[8 +: STIME_W];
    ins.slow  = word[14];
    if (word == W_HOME)
      ins.op = OP_HOME;
    else if (word == W_OFF)
      ins.op = OP_OFF;
    else if (word == W_ON)
      ins.op = OP_ON;
    else if (word[15])
      ins.op = word[13] ? OP_HOME : OP_NOP;
    else if ((|word[8 +: STIME_W]) && (|word[STEPS_W-1:0]))
      ins.op = OP_RAMP;
  end

endmodule

// File: rtl/pwm_ramp_exec.sv
module pwm_ramp_exec
  import pwm_seq_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             tick,
  input  instr_t           ins,
  output logic [AW-1:0]    pc,
  output logic [LVL_W-1:0] level,
  output logic             force_on,
  output logic             force_off
);

  logic [AW-1:0]      pc_q, pc_d;
  logic [LVL_W-1:0]   lvl_q, lvl_d;
  logic               ramp_q, ramp_d;
  logic               down_q, down_d;
  logic [STEPS_W-1:0] steps_q, steps_d;
  logic [PER_W-1:0]   per_q, per_d;
  logic [PER_W-1:0]   tc_q, tc_d;
  logic               fon_q, fon_d;
  logic               foff_q, foff_d;
  logic [PER_W-1:0]   new_per;

  assign new_per = ins.slow ? {ins.stime, {PSC_SH{1'b0}}}
                            : {{PSC_SH{1'b0}}, ins.stime};

  always_comb begin
    pc_d    = pc_q;
    lvl_d   = lvl_q;
    ramp_d  = ramp_q;
    down_d  = down_q;
    steps_d = steps_q;
    per_d   = per_q;
    tc_d    = tc_q;
    fon_d   = fon_q;
    foff_d  = foff_q;
    if (!run) begin
      pc_d   = '0;
      lvl_d  = '0;
      ramp_d = 1'b0;
      tc_d   = '0;
      fon_d  = 1'b0;
      foff_d = 1'b0;
    end else if (ramp_q) begin
      if (tick) begin
        if (tc_q == per_q - PER_W'(1)) begin
          tc_d    = '0;
          steps_d = steps_q - 1'b1;
          if (down_q) lvl_d = (lvl_q == '0) ? lvl_q : lvl_q - 1'b1;
          else        lvl_d = (lvl_q == '1) ? lvl_q : lvl_q + 1'b1;
          if (steps_q == STEPS_W'(1)) begin
            ramp_d = 1'b0;
            pc_d   = pc_q + 1'b1;
          end
        end else begin
          tc_d = tc_q + 1'b1;
        end
      end
    end else begin
      unique case (ins.op)
        OP_HOME: pc_d = '0;
        OP_OFF: begin
          foff_d = 1'b1;
          fon_d  = 1'b0;
          pc_d   = pc_q + 1'b1;
        end
        OP_ON: begin
          fon_d  = 1'b1;
          foff_d = 1'b0;
          pc_d   = pc_q + 1'b1;
        end
        OP_RAMP: begin
          ramp_d  = 1'b1;
          down_d  = ins.down;
          steps_d = ins.steps;
          per_d   = new_per;
          tc_d    = '0;
          fon_d   = 1'b0;
          foff_d  = 1'b0;
        end
        default: pc_d = pc_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      lvl_q   <= '0;
      ramp_q  <= 1'b0;
      down_q  <= 1'b0;
      steps_q <= '0;
      per_q   <= '0;
      tc_q    <= '0;
      fon_q   <= 1'b0;
      foff_q  <= 1'b0;
    end else begin
      pc_q    <= pc_d;
      lvl_q   <= lvl_d;
      ramp_q  <= ramp_d;
      down_q  <= down_d;
      steps_q <= steps_d;
      per_q   <= per_d;
      tc_q    <= tc_d;
      fon_q   <= fon_d;
      foff_q  <= foff_d;
    end
  end

  assign pc        = pc_q;
  assign level     = lvl_q;
  assign force_on  = fon_q;
  assign force_off = foff_q;

endmodule

// File: rtl/pwm_ramp_seq.sv
module pwm_ramp_seq
  import pwm_seq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run_en,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              pwm_out
);

  localparam int AW = $clog2(DEPTH);

  logic [1:0]        rsync_q;
  logic              rst_ni;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              running_q;
  logic [AW-1:0]     pc;
  logic [WORD_W-1:0] word;
  instr_t            ins;
  logic [CNT_W-1:0]  level;
  logic              force_on;
  logic              force_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    cnt_d = cnt_q;
    if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      running_q <= run_en;
    end
  end

  pwm_prog_store #(.DEPTH(DEPTH)) store_i (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load_ok  (!run_en),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte),
    .rd_addr  (pc),
    .rd_word  (word)
  );

  pwm_instr_decode dec_i (
    .word (word),
    .ins  (ins)
  );

  pwm_ramp_exec #(.AW(AW), .LVL_W(CNT_W)) exec_i (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .run       (run_en),
    .tick      (tick),
    .ins       (ins),
    .pc        (pc),
    .level     (level),
    .force_on  (force_on),
    .force_off (force_off)
  );

  assign pwm_out = running_q & (force_on | (!force_off & (level > cnt_q)));

endmodule

// File: rtl/pwm_ramp_seq_chk.sv
module pwm_ramp_seq_chk #(
  parameter int AW    = 6,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             tick,
  input logic             run_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] level,
  input logic [AW-1:0]    pc,
  input logic             pwm_out
);

  AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_ni)
    tick |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R1

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> $stable(cnt)); // R1

  AST_OUT_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_en |=> !pwm_out); // R2

  AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    !run_en |=> (level == '0) && (pc == '0)); // R8

  AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_en && !tick) |=> $stable(level)); // R10

  AST_LEVEL_UNIT: assert property (@(posedge clk) disable iff (!rst_ni)
    run_en |=> (level == $past(level)) ||
               (level == CNT_W'($past(level) + 1'b1)) ||
               (level == CNT_W'($past(level) - 1'b1))); // R10

endmodule

bind pwm_ramp_seq pwm_ramp_seq_chk #(.AW(AW), .CNT_W(CNT_W)) chk_i (
  .clk     (clk),
  .rst_ni  (rst_ni),
  .tick    (tick),
  .run_en  (run_en),
  .cnt     (cnt_q),
  .level   (level),
  .pc      (pc),
  .pwm_out (pwm_out)
);

// File: tb/pwm_ramp_seq_tb_top.sv
`timescale 1ns/1ps
module pwm_ramp_seq_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       run_en;
  logic       wr_valid;
  logic [7:0] wr_byte;
  logic       pwm_out;

  int nchk = 0;
  int nbad = 0;
  int wd   = 0;
  int phase = 0;
  bit checking = 0;
  string cur_req = "R2";

  // behavioural reference state
  int  m_mem [64];
  int  m_ptr, m_hi, m_cnt, m_lvl, m_pc, m_steps, m_per, m_tc;
  bit  m_ramp, m_dir, m_fon, m_foff, m_run, m_rs1, m_rs2;

  pwm_ramp_seq dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run_en   (run_en),
    .wr_valid (wr_valid),
    .wr_byte  (wr_byte),
    .pwm_out  (pwm_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic model_clear();
    m_cnt = 0; m_lvl = 0; m_pc = 0; m_ramp = 0; m_tc = 0;
    m_fon = 0; m_foff = 0; m_run = 0; m_ptr = 0; m_hi = 0;
    m_steps = 0; m_per = 0; m_dir = 0;
  endtask

  task automatic model_exec();
    int w;
    if (m_ramp) begin
      if (tick) begin
        if (m_tc + 1 == m_per) begin
          m_tc = 0;
          if (m_dir) m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
          else       m_lvl = (m_lvl < 255) ? m_lvl + 1 : 255;
          if (m_steps == 1) begin
            m_ramp = 0;
            m_pc = (m_pc + 1) % 64;
          end
          m_steps = m_steps - 1;
        end else begin
          m_tc = m_tc + 1;
        end
      end
    end else begin
      w = m_mem[m_pc];
      if (w == 0) m_pc = 0;
      else if (w == 'h7F) begin m_foff = 1; m_fon = 0; m_pc = (m_pc + 1) % 64; end
      else if (w == 'hFF) begin m_fon = 1; m_foff = 0; m_pc = (m_pc + 1) % 64; end
      else if ((w & 'h8000) != 0) m_pc = ((w & 'h2000) != 0) ? 0 : (m_pc + 1) % 64;
      else if (((w >> 8) & 63) != 0 && (w & 127) != 0) begin
        m_ramp = 1; m_steps = w & 127; m_dir = ((w >> 7) & 1) != 0;
        m_per = ((w >> 8) & 63) * (((w & 'h4000) != 0) ? 512 : 1);
        m_tc = 0; m_fon = 0; m_foff = 0;
      end else m_pc = (m_pc + 1) % 64;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_clear();
      m_rs1 = 0; m_rs2 = 0;
    end else begin
      if (!m_rs2) model_clear();
      else begin
        if (tick) m_cnt = (m_cnt + 1) % 256;
        if (!run_en) begin
          m_pc = 0; m_lvl = 0; m_ramp = 0; m_tc = 0; m_fon = 0; m_foff = 0;
          if (wr_valid) begin
            if (m_ptr % 2 == 0) m_hi = wr_byte;
            else m_mem[m_ptr / 2] = m_hi * 256 + int'(wr_byte);
            m_ptr = (m_ptr + 1) % 128;
          end
        end else begin
          m_ptr = 0;
          model_exec();
        end
        m_run = run_en;
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      bit exp;
      exp = m_run && (m_fon || (!m_foff && (m_lvl > m_cnt)));
      nchk++;
      if (pwm_out !== exp) begin
        nbad++;
        $display("FAIL %s: pwm_out=%0b expected %0b (level=%0d count=%0d) t=%0t",
                 cur_req, pwm_out, exp, m_lvl, m_cnt, $time);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      nbad++;
      $display("FAIL R2 watchdog: cycles=%0d expected below 100000", wd);
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) begin
      @(negedge clk);
      phase++;
      tick = (phase % 2 == 0);
      wr_valid = 1'b0;
    end
  endtask

  task automatic put_byte(input logic [7:0] b);
    cyc(1);
    wr_valid = 1'b1;
    wr_byte  = b;
  endtask

  task automatic put_word(input logic [15:0] w);
    put_byte(w[15:8]);
    put_byte(w[7:0]);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; run_en = 1'b0; wr_valid = 1'b0; wr_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(4);
    nchk++;
    if (pwm_out !== 1'b0) begin
      nbad++;
      $display("FAIL R2 reset: pwm_out=%0b expected 0", pwm_out);
    end
    checking = 1;

    // force-on then jump home
    cur_req = "R3 R5 R4";
    put_word(16'h00FF); put_word(16'h0000);
    cyc(2); run_en = 1'b1;
    cyc(600);

    // ramp up in a loop until saturation
    cur_req = "R6 R7 R4 R1";
    run_en = 1'b0; cyc(2);
    put_word(16'h0114); put_word(16'hA000);
    cyc(2); run_en = 1'b1;
    cyc(800);

    // writes while running are ignored
    cur_req = "R3 ignored";
    put_word(16'h007F); put_word(16'h007F);
    cyc(200);

    // restart without new writes: same program from level 0
    cur_req = "R8 R3";
    run_en = 1'b0; cyc(3);
    run_en = 1'b1;
    cyc(900);

    // mixed program with no-op words and a force-off
    cur_req = "R6 R9 R5 R10";
    run_en = 1'b0; cyc(2);
    put_word(16'h0232); put_word(16'h0385); put_word(16'h4101);
    put_word(16'h8000); put_word(16'h0010); put_word(16'h2000);
    put_word(16'h007F); put_word(16'h0000);
    cyc(2); run_en = 1'b1;
    cyc(4000);

    // ramp down from zero saturates, then force-on
    cur_req = "R7 R5 R2";
    run_en = 1'b0; cyc(2);
    put_word(16'h01FF); put_word(16'h00FF); put_word(16'h0000);
    cyc(2); run_en = 1'b1;
    cyc(1500);

    cur_req = "R2 idle";
    run_en = 1'b0;
    cyc(300);

    checking = 0;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule